// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a software-serviced watchdog. One 8-bit control register holds the whole configuration: a 2-bit resolution code, a 5-bit multiplier and a steering bit. The timeout is counted in periods of a 1/16-second tick enable that arrives from outside. Any write to the control register, and any read of it, counts as servicing. Servicing clears the expiry flag and starts the countdown again. A write loads a new setting. A read reloads the setting already stored.

When the countdown runs out, the block sets a sticky expiry flag. It then does one of two things, chosen by the steering bit. With steering set, it requests a system reset, clears the control register, and pulses a strobe that clears a status bit held elsewhere. With steering clear, it raises a single-cycle interrupt pulse. Either way the watchdog then goes idle until software services it again. Writing all zeros turns the watchdog off.

Top module: `wdg_steer`

## Requirements
- R1: After a synchronous reset, rd_data is 0x00, wd_flag, irq, rst_req and dow_clr are low, and no tick causes an expiry until the register is written.
- R2: The timeout in ticks is mult × 4^res, where res is wr_data[1:0] and mult is wr_data[6:2]. Expiry happens on exactly that tick after the last service and on no earlier tick.
- R3: A nonzero value whose timeout works out to zero (mult = 0) expires on the first tick after the write.
- R4: Writing 0x00 stops the watchdog, and no tick causes an expiry afterwards.
- R5: A write (wr_en high for one cycle) stores wr_data, clears wd_flag and restarts the countdown from the new value.
- R6: A read (rd_en high for one cycle) presents the stored register on rd_data, clears wd_flag and restarts the countdown from the stored value.
- R7: At expiry wd_flag goes high, and it stays high until the next read or write.
- R8: When wr_data[7] was set, expiry raises rst_req and dow_clr together for exactly one cycle, clears the register to 0x00, and does not raise irq.
- R9: When wr_data[7] was clear, expiry raises irq for exactly one cycle, does not raise rst_req or dow_clr, and leaves the register unchanged.
- R10: The countdown moves only on cycles where tick is high. After an expiry the watchdog stays idle until it is serviced again.
- R11: When wr_en and rd_en are high in the same cycle, the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 1/16-second count enable |
| wr_en | input | 1 | Control register write strobe |
| rd_en | input | 1 | Control register read strobe |
| wr_data | input | 8 | Value to write: steer[7], mult[6:2], res[1:0] |
| rd_data | output | 8 | Stored control register |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |
| wd_flag | output | 1 | Sticky expiry flag |
| dow_clr | output | 1 | One-cycle strobe that clears an external status bit |

## Verification
The assertions assume that tick, wr_en and rd_en are synchronous to clk and are sampled only at rising edges. They do not assume anything about the spacing between ticks or between accesses. The bench drives every input on the falling edge and holds each strobe for one full cycle. It also inserts idle cycles between ticks. This lets the checks confirm that the countdown ignores cycles without a tick, while keeping the random settings inside the 5-bit multiplier and 2-bit resolution fields.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int RES_W  = 2;
    localparam int MULT_W = 5;
    localparam int CTRL_W = 1 + MULT_W + RES_W;
    // widest shift is 2*(2^RES_W - 1) bits
    localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

    typedef struct packed {
        logic              steer_rst;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wdg_ctrl_t;

    function automatic logic [CNT_W-1:0] wdg_timeout(wdg_ctrl_t c);
        logic [CNT_W-1:0] base;
        base = CNT_W'(c.mult);
        return base << {c.res, 1'b0};
    endfunction
endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  wdg_ctrl_t wr_val,
    input  logic      fire_clear,
    output wdg_ctrl_t ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_val;
        end else if (fire_clear) begin
            ctrl_q <= '0;
        end
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  wdg_ctrl_t load_val,
    input  logic      tick,
    output logic      fire
);
    logic [CNT_W-1:0] remain_q;
    logic             armed_q;
    logic             last_tick;

    assign last_tick = (remain_q <= CNT_W'(1));
    assign fire      = tick && armed_q && !load && last_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            armed_q  <= 1'b0;
        end else if (load) begin
            remain_q <= wdg_timeout(load_val);
            armed_q  <= (load_val != '0);
        end else if (tick && armed_q) begin
            if (last_tick) begin
                armed_q <= 1'b0;
            end else begin
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdg_expiry.sv
module wdg_expiry (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic steer_rst,
    input  logic access,
    output logic flag_q,
    output logic irq_q,
    output logic rst_req_q,
    output logic clr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q    <= 1'b0;
            irq_q     <= 1'b0;
            rst_req_q <= 1'b0;
            clr_q     <= 1'b0;
        end else begin
            irq_q     <= fire && !steer_rst;
            rst_req_q <= fire && steer_rst;
            clr_q     <= fire && steer_rst;
            if (access) begin
                flag_q <= 1'b0;
            end else if (fire) begin
                flag_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdg_steer.sv
module wdg_steer
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              rst_req,
    output logic              irq,
    output logic              wd_flag,
    output logic              dow_clr
);
    wdg_ctrl_t ctrl_q;
    wdg_ctrl_t wr_val;
    wdg_ctrl_t load_val;
    logic      access;
    logic      fire;

    assign wr_val   = wdg_ctrl_t'(wr_data);
    assign access   = wr_en || rd_en;
    assign load_val = wr_en ? wr_val : ctrl_q;
    assign rd_data  = ctrl_q;

    wdg_ctrl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_val     (wr_val),
        .fire_clear (fire && ctrl_q.steer_rst),
        .ctrl_q     (ctrl_q)
    );

    wdg_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (access),
        .load_val (load_val),
        .tick     (tick),
        .fire     (fire)
    );

    wdg_expiry u_exp (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .steer_rst (ctrl_q.steer_rst),
        .access    (access),
        .flag_q    (wd_flag),
        .irq_q     (irq),
        .rst_req_q (rst_req),
        .clr_q     (dow_clr)
    );
endmodule

// File: rtl/wdg_steer_chk.sv
module wdg_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       rst_req,
    input logic       irq,
    input logic       wd_flag,
    input logic       dow_clr
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R9
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req); // R8
    AST_STEER_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(irq && rst_req)); // R8
    AST_RST_CLEARS_REG: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (rd_data == 8'h00 && dow_clr)); // R8
    AST_FLAG_AT_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (irq || rst_req) |-> wd_flag); // R7
    AST_ACCESS_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_en || rd_en) |=> !wd_flag); // R5
    AST_FIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tick)); // R10
endmodule

bind wdg_steer wdg_steer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .rst_req (rst_req),
    .irq     (irq),
    .wd_flag (wd_flag),
    .dow_clr (dow_clr)
);

// File: tb/wdg_steer_bench.sv
module wdg_steer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_TICKS  = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rst_req, irq, wd_flag, dow_clr;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_steer u_wdg_steer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req), .irq(irq),
        .wd_flag(wd_flag), .dow_clr(dow_clr)
    );

    function automatic int exp_ticks(logic [7:0] v);
        int t;
        t = int'(v[6:2]) << (2 * int'(v[1:0]));
        return (t == 0) ? 1 : t;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; v = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // one tick, then an idle cycle; outputs sampled right after the tick edge
    task automatic one_tick(output bit fired);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        fired = irq || rst_req;
    endtask

    task automatic run_to_fire(output int n, output bit was_rst);
        bit f;
        n = 0; was_rst = 1'b0;
        for (int i = 1; i <= MAX_TICKS; i++) begin
            one_tick(f);
            if (f) begin
                n = i; was_rst = rst_req;
                check(wd_flag == 1'b1, "R7", wd_flag, 1);
                if (rst_req) check(dow_clr == 1'b1 && rd_data == 8'h00, "R8", rd_data, 0);
                break;
            end
        end
        @(negedge clk);
        check(!irq && !rst_req && !dow_clr, "R8/R9 pulse width", irq + rst_req, 0);
    endtask

    task automatic quiet_ticks(input int k, input string req);
        bit f;
        int hits = 0;
        for (int i = 0; i < k; i++) begin
            one_tick(f);
            if (f) hits++;
        end
        check(hits == 0, req, hits, 0);
    endtask

    initial begin
        repeat (MAX_TICKS * 80) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        bit r;
        bit f;
        logic [7:0] v;
        logic [7:0] got;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 8'h00 && !wd_flag && !irq && !rst_req && !dow_clr, "R1", rd_data, 0);
        quiet_ticks(20, "R1 idle after reset");

        // R2 directed: res=1 mult=1 -> 4 ticks, interrupt path
        wr(8'h05);
        run_to_fire(n, r);
        check(n == 4, "R2", n, 4);
        check(r == 1'b0, "R9 kind", r, 0);
        check(rd_data == 8'h05, "R9 reg kept", rd_data, 5);
        // R10 one-shot and flag sticky
        quiet_ticks(12, "R10 one-shot");
        check(wd_flag == 1'b1, "R7 sticky", wd_flag, 1);

        // R6 read clears flag and restarts
        rd(got);
        check(got == 8'h05, "R6 rd_data", got, 5);
        check(wd_flag == 1'b0, "R6 flag", wd_flag, 0);
        run_to_fire(n, r);
        check(n == 4, "R6 restart", n, 4);

        // R5 write mid-count restarts
        wr(8'h05);
        for (int i = 0; i < 3; i++) one_tick(f);
        wr(8'h05);
        run_to_fire(n, r);
        check(n == 4, "R5 restart", n, 4);
        wr(8'h09);
        check(wd_flag == 1'b0 && rd_data == 8'h09, "R5 flag/store", wd_flag, 0);

        // R10 no tick, no countdown
        wr(8'h04);
        repeat (40) @(negedge clk);
        check(!irq && !wd_flag, "R10 no tick", irq, 0);
        run_to_fire(n, r);
        check(n == 1, "R10 count held", n, 1);

        // R4 zero stops
        wr(8'h7F);
        for (int i = 0; i < 5; i++) one_tick(f);
        wr(8'h00);
        quiet_ticks(60, "R4 stopped");

        // R3 zero timeout with steering set
        wr(8'h82);
        run_to_fire(n, r);
        check(n == 1, "R3", n, 1);
        check(r == 1'b1, "R8 kind", r, 1);
        check(rd_data == 8'h00, "R8 reg cleared", rd_data, 0);
        quiet_ticks(10, "R8 idle after reset path");

        // R11 write wins over read
        wr(8'h11);
        @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h00;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        check(rd_data == 8'h00, "R11 store", rd_data, 0);
        quiet_ticks(30, "R11 stopped");

        // random settings
        for (int k = 0; k < 16; k++) begin
            v = 8'($urandom);
            if (v == 8'h00) v = 8'h05;
            wr(v);
            run_to_fire(n, r);
            check(n == exp_ticks(v), "R2 random", n, exp_ticks(v));
            check(r == v[7], "R8/R9 random kind", r, v[7]);
            check(rd_data == (v[7] ? 8'h00 : v), "R8/R9 random reg", rd_data, v[7] ? 0 : v);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule